// File: doc/BRIEF.md
# Connection Identifier Lookup Controller

This block sits in a cell receive pipeline. For every arriving cell it turns the cell's connection identifier into a short internal reference number, which the next stage uses as a list handle. It keeps two independent associative tables. The circuit table is keyed by the 16-bit virtual circuit identifier (VCI). The message table is keyed by the VCI joined with a 10-bit multiplex identifier (MID), and it serves connectionless traffic.

If the lookup misses and the chosen table still has a free slot, the block claims that slot for the identifier and reports the index as a new connection. If the table is full, the cell is dropped and no index goes out. A host side port can read back the key held in any slot and can delete a slot. A delete frees the slot and sends a deallocation request for that index to the later stages.

Each lookup resolves in one clock. Host operations use only the cycles in which no cell is presented.

Top module: `conn_lookup_ctrl`

## Requirements
- R1: After a synchronous active-low reset every slot of both tables is free, and `ref_valid`, `cell_drop`, `host_rd_valid` and `dealloc_valid` are all 0.
- R2: A circuit cell (`cell_is_cl`=0) whose VCI equals the key of a slot in use is answered with `ref_valid`=1, `ref_new`=0, `ref_cl`=0 and that slot's index. A key is never stored in two slots.
- R3: A cell that misses while its table has a free slot is stored in the lowest-numbered free slot and answered with `ref_valid`=1, `ref_new`=1 and that index. A slot freed by a delete becomes a candidate again.
- R4: A cell that misses while every slot of its table is in use is answered with `cell_drop`=1 and `ref_valid`=0. The table is left unchanged.
- R5: A message cell (`cell_is_cl`=1) is looked up in the message table by the 26-bit key {VCI, MID}. Two cells that differ only in MID get different slots. The two tables allocate independently of each other.
- R6: The answer to a cell presented in cycle N appears in cycle N+1. A cell in cycle N+1 already sees a slot claimed in cycle N.
- R7: A host read (`host_op_del`=0) of slot `host_idx` in the table chosen by `host_sel_cl` returns, one cycle after acceptance, `host_rd_valid`=1, the in-use flag, and the key. For a message slot the key is {VCI in bits 25:10, MID in bits 9:0}. For a circuit slot the VCI is in bits 15:0 and bits 25:16 are zero.
- R8: A host delete (`host_op_del`=1) of a slot in use frees it and, one cycle after acceptance, pulses `dealloc_valid` with `dealloc_cl` and `dealloc_idx` naming the slot. Deleting a free slot produces no pulse.
- R9: A host request is accepted (`host_accept`=1) only in a cycle in which `cell_valid` is 0. A request made while a cell is present waits, and has no effect, until such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cell_valid | input | 1 | A cell identifier is presented this cycle |
| cell_is_cl | input | 1 | 1: message table (VCI+MID), 0: circuit table (VCI) |
| cell_vci | input | 16 | Virtual circuit identifier of the cell |
| cell_mid | input | 10 | Multiplex identifier (used for message cells only) |
| ref_valid | output | 1 | An internal reference is delivered |
| ref_new | output | 1 | The reference was just allocated |
| ref_cl | output | 1 | The reference belongs to the message table |
| ref_idx | output | 8 | Internal reference number (slot index) |
| cell_drop | output | 1 | The cell missed in a full table and is dropped |
| host_req | input | 1 | Host operation requested |
| host_op_del | input | 1 | 1: delete, 0: read |
| host_sel_cl | input | 1 | Table selected by the host operation |
| host_idx | input | 8 | Slot addressed by the host |
| host_accept | output | 1 | Host request taken this cycle |
| host_rd_valid | output | 1 | Read result is valid |
| host_rd_used | output | 1 | The slot read was in use |
| host_rd_key | output | 26 | Key stored in the slot read |
| dealloc_valid | output | 1 | Deallocation request for a later stage |
| dealloc_cl | output | 1 | Table of the deallocated slot |
| dealloc_idx | output | 8 | Index of the deallocated slot |

## Verification
The bench fills the circuit table completely through back-to-back cells, then sends one more new identifier. A design that wrapped around, or that overwrote a slot, would return an index instead of dropping, and the hits checked afterwards would show the damage. Message cells that share a VCI but differ in MID must land in separate slots and must not disturb circuit allocation; a design that keys on VCI alone would report a hit. After a delete, the next new identifier must take the freed low slot rather than a higher one. Deleting a free slot must stay silent, and a host read raised alongside a cell must wait. A design that serviced it at once would grant access in the cell's cycle.

// File: rtl/clu_pkg.sv
// Package: shared widths for the connection identifier lookup block.
package clu_pkg;
    localparam int VCI_W = 16;  // virtual circuit identifier width
    localparam int MID_W = 10;  // multiplex identifier width
    localparam int CL_KEY_W = VCI_W + MID_W;  // message table key width

    // Result kinds seen at the reference output (documentation aid)
    typedef enum logic [1:0] {
        RES_HIT  = 2'd0,
        RES_NEW  = 2'd1,
        RES_DROP = 2'd2
    } res_kind_e;
endpackage

// File: rtl/clu_lowest_set.sv
// clu_lowest_set: returns the index of the lowest set bit of a vector.
// Assumes: purely combinational; idx is 0 when no bit is set.
module clu_lowest_set #(
    parameter int W = 256,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so that the lowest set bit wins
    always_comb begin
        found = |vec;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/clu_table.sv
// clu_table: one associative table with per-slot valid bits.
// Matches the search key against every slot in parallel, reports a hit and
// the lowest free slot, and claims or frees a slot on request.
// Assumes: the caller never claims and frees the same slot in one cycle.
module clu_table #(
    parameter int ENTRIES = 256,
    parameter int KEY_W = 16,
    parameter int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] srch_key,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic             has_free,
    output logic [IDX_W-1:0] free_idx,
    input  logic             alloc_en,
    input  logic             del_en,
    input  logic [IDX_W-1:0] del_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [KEY_W-1:0] rd_key,
    output logic             rd_used
);
    logic [ENTRIES-1:0] valid_q;
    logic [KEY_W-1:0]   key_q [ENTRIES];
    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] free_vec;

    // Compare the search key against every slot in use
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid_q[g] && (key_q[g] == srch_key);
        assign free_vec[g]  = !valid_q[g];
    end

    clu_lowest_set #(.W(ENTRIES), .IDX_W(IDX_W)) i_hit_enc (
        .vec   (match_vec),
        .found (hit),
        .idx   (hit_idx)
    );

    clu_lowest_set #(.W(ENTRIES), .IDX_W(IDX_W)) i_free_enc (
        .vec   (free_vec),
        .found (has_free),
        .idx   (free_idx)
    );

    // Claim the lowest free slot or free an addressed slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) key_q[i] <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (alloc_en && free_idx == IDX_W'(i)) begin
                    valid_q[i] <= 1'b1;
                    key_q[i]   <= srch_key;
                end else if (del_en && del_idx == IDX_W'(i)) begin
                    valid_q[i] <= 1'b0;
                end
            end
        end
    end

    // Host side read port
    always_comb begin
        rd_key  = key_q[rd_idx];
        rd_used = valid_q[rd_idx];
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec)); // R2
    AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> (has_free && !hit)); // R3
    AST_NO_SAME_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_en && del_en)); // R9
endmodule

// File: rtl/conn_lookup_ctrl.sv
// conn_lookup_ctrl: maps a cell's connection identifier to an internal
// reference using a circuit table (VCI key) and a message table
// ({VCI, MID} key). A miss claims the lowest free slot, and a full table
// drops the cell. The host reads or deletes slots in idle cycles, and a
// delete of a used slot emits a deallocation request downstream.
// Assumes: one cell per cycle at most; the result follows one cycle later.
module conn_lookup_ctrl #(
    parameter int ENTRIES = 256,
    parameter int VCI_W = clu_pkg::VCI_W,
    parameter int MID_W = clu_pkg::MID_W,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int CLK_W = VCI_W + MID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_valid,
    input  logic             cell_is_cl,
    input  logic [VCI_W-1:0] cell_vci,
    input  logic [MID_W-1:0] cell_mid,
    output logic             ref_valid,
    output logic             ref_new,
    output logic             ref_cl,
    output logic [IDX_W-1:0] ref_idx,
    output logic             cell_drop,
    input  logic             host_req,
    input  logic             host_op_del,
    input  logic             host_sel_cl,
    input  logic [IDX_W-1:0] host_idx,
    output logic             host_accept,
    output logic             host_rd_valid,
    output logic             host_rd_used,
    output logic [CLK_W-1:0] host_rd_key,
    output logic             dealloc_valid,
    output logic             dealloc_cl,
    output logic [IDX_W-1:0] dealloc_idx
);
    logic             vc_hit, vc_free_any, vc_alloc, vc_del, vc_rd_used;
    logic             cl_hit, cl_free_any, cl_alloc, cl_del, cl_rd_used;
    logic [IDX_W-1:0] vc_hit_idx, vc_free_idx, cl_hit_idx, cl_free_idx;
    logic [VCI_W-1:0] vc_rd_key;
    logic [CLK_W-1:0] cl_rd_key;
    logic             sel_hit, sel_free, del_req, sel_used;
    logic [IDX_W-1:0] sel_hit_idx, sel_free_idx;

    // Pick the table answering this cell and decide the host action
    always_comb begin
        host_accept  = host_req && !cell_valid;
        del_req      = host_accept && host_op_del;
        sel_hit      = cell_is_cl ? cl_hit : vc_hit;
        sel_free     = cell_is_cl ? cl_free_any : vc_free_any;
        sel_hit_idx  = cell_is_cl ? cl_hit_idx : vc_hit_idx;
        sel_free_idx = cell_is_cl ? cl_free_idx : vc_free_idx;
        sel_used     = host_sel_cl ? cl_rd_used : vc_rd_used;
        vc_alloc     = cell_valid && !cell_is_cl && !vc_hit && vc_free_any;
        cl_alloc     = cell_valid && cell_is_cl && !cl_hit && cl_free_any;
        vc_del       = del_req && !host_sel_cl && vc_rd_used;
        cl_del       = del_req && host_sel_cl && cl_rd_used;
    end

    clu_table #(.ENTRIES(ENTRIES), .KEY_W(VCI_W), .IDX_W(IDX_W)) i_vc_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .srch_key (cell_vci),
        .hit      (vc_hit),
        .hit_idx  (vc_hit_idx),
        .has_free (vc_free_any),
        .free_idx (vc_free_idx),
        .alloc_en (vc_alloc),
        .del_en   (vc_del),
        .del_idx  (host_idx),
        .rd_idx   (host_idx),
        .rd_key   (vc_rd_key),
        .rd_used  (vc_rd_used)
    );

    clu_table #(.ENTRIES(ENTRIES), .KEY_W(CLK_W), .IDX_W(IDX_W)) i_cl_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .srch_key ({cell_vci, cell_mid}),
        .hit      (cl_hit),
        .hit_idx  (cl_hit_idx),
        .has_free (cl_free_any),
        .free_idx (cl_free_idx),
        .alloc_en (cl_alloc),
        .del_en   (cl_del),
        .del_idx  (host_idx),
        .rd_idx   (host_idx),
        .rd_key   (cl_rd_key),
        .rd_used  (cl_rd_used)
    );

    // Register the lookup answer for the list stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_valid <= 1'b0;
            ref_new   <= 1'b0;
            ref_cl    <= 1'b0;
            ref_idx   <= '0;
            cell_drop <= 1'b0;
        end else begin
            ref_valid <= cell_valid && (sel_hit || sel_free);
            ref_new   <= cell_valid && !sel_hit && sel_free;
            ref_cl    <= cell_valid && cell_is_cl;
            ref_idx   <= !cell_valid ? '0 : (sel_hit ? sel_hit_idx : sel_free_idx);
            cell_drop <= cell_valid && !sel_hit && !sel_free;
        end
    end

    // Register host read data and deallocation requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rd_valid <= 1'b0;
            host_rd_used  <= 1'b0;
            host_rd_key   <= '0;
            dealloc_valid <= 1'b0;
            dealloc_cl    <= 1'b0;
            dealloc_idx   <= '0;
        end else begin
            host_rd_valid <= host_accept && !host_op_del;
            host_rd_used  <= sel_used;
            host_rd_key   <= host_sel_cl ? cl_rd_key : {{MID_W{1'b0}}, vc_rd_key};
            dealloc_valid <= vc_del || cl_del;
            dealloc_cl    <= host_sel_cl;
            dealloc_idx   <= host_idx;
        end
    end

    AST_HIT_OR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_valid && cell_drop)); // R4
    AST_NEW_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ref_new |-> ref_valid); // R3
    AST_ANSWER_FOLLOWS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid || cell_drop) |-> $past(cell_valid)); // R6
    AST_DEALLOC_FROM_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        dealloc_valid |-> $past(host_req && host_op_del && !cell_valid)); // R8
    AST_HOST_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_valid |-> $past(!cell_valid)); // R9
endmodule

// File: tb/test_conn_lookup_ctrl.sv
// Scoreboard bench: driver tasks model the tables, push expected answers;
// a monitor pops them as results appear.
module test_conn_lookup_ctrl;
    localparam int N = 256;
    localparam int IW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cell_valid = 1'b0, cell_is_cl = 1'b0;
    logic [15:0] cell_vci = '0;
    logic [9:0] cell_mid = '0;
    logic ref_valid, ref_new, ref_cl, cell_drop;
    logic [IW-1:0] ref_idx;
    logic host_req = 1'b0, host_op_del = 1'b0, host_sel_cl = 1'b0;
    logic [IW-1:0] host_idx = '0;
    logic host_accept, host_rd_valid, host_rd_used, dealloc_valid, dealloc_cl;
    logic [25:0] host_rd_key;
    logic [IW-1:0] dealloc_idx;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model of both tables
    bit          m_used [2][N];
    logic [25:0] m_key  [2][N];
    logic [10:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;  // 125 MHz

    conn_lookup_ctrl i_conn_lookup_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cell_valid(cell_valid), .cell_is_cl(cell_is_cl),
        .cell_vci(cell_vci), .cell_mid(cell_mid),
        .ref_valid(ref_valid), .ref_new(ref_new), .ref_cl(ref_cl),
        .ref_idx(ref_idx), .cell_drop(cell_drop),
        .host_req(host_req), .host_op_del(host_op_del),
        .host_sel_cl(host_sel_cl), .host_idx(host_idx),
        .host_accept(host_accept), .host_rd_valid(host_rd_valid),
        .host_rd_used(host_rd_used), .host_rd_key(host_rd_key),
        .dealloc_valid(dealloc_valid), .dealloc_cl(dealloc_cl),
        .dealloc_idx(dealloc_idx)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model a lookup and queue the expected answer {kind, cl, idx}
    task automatic expect_cell(input bit cl, input logic [15:0] vci,
                               input logic [9:0] mid, input string tag);
        logic [25:0] key;
        int hit, fr;
        key = cl ? {vci, mid} : {10'b0, vci};
        hit = -1;
        fr = -1;
        for (int i = 0; i < N; i++) begin
            if (m_used[cl][i] && m_key[cl][i] == key && hit < 0) hit = i;
            if (!m_used[cl][i] && fr < 0) fr = i;
        end
        if (hit >= 0) exp_q.push_back({2'd0, cl, IW'(hit)});
        else if (fr >= 0) begin
            exp_q.push_back({2'd1, cl, IW'(fr)});
            m_used[cl][fr] = 1;
            m_key[cl][fr] = key;
        end else exp_q.push_back({2'd2, 1'b0, IW'(0)});
        tag_q.push_back(tag);
    endtask

    task automatic send_cell(input bit cl, input logic [15:0] vci,
                             input logic [9:0] mid, input string tag);
        @(negedge clk);
        expect_cell(cl, vci, mid, tag);
        cell_valid = 1; cell_is_cl = cl; cell_vci = vci; cell_mid = mid;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cell_valid = 0;
        end
    endtask

    task automatic host_read(input bit cl, input int idx, input string tag);
        logic [25:0] ek;
        bit eu;
        @(negedge clk);
        eu = m_used[cl][idx];
        ek = m_key[cl][idx];
        host_req = 1; host_op_del = 0; host_sel_cl = cl; host_idx = IW'(idx);
        #1 check(host_accept === 1'b1, {tag, " accept"}, 32'(host_accept), 32'd1);
        @(negedge clk);
        host_req = 0;
        check(host_rd_valid === 1'b1 && host_rd_used === eu, {tag, " used"},
              32'({host_rd_valid, host_rd_used}), 32'({1'b1, eu}));
        if (eu) check(host_rd_key === ek, {tag, " key"}, 32'(host_rd_key), 32'(ek));
    endtask

    task automatic host_delete(input bit cl, input int idx, input string tag);
        bit ed;
        @(negedge clk);
        ed = m_used[cl][idx];
        m_used[cl][idx] = 0;
        host_req = 1; host_op_del = 1; host_sel_cl = cl; host_idx = IW'(idx);
        @(negedge clk);
        host_req = 0;
        check(dealloc_valid === ed, {tag, " dealloc"}, 32'(dealloc_valid), 32'(ed));
        if (ed) check({dealloc_cl, dealloc_idx} === {cl, IW'(idx)}, {tag, " dealloc slot"},
                      32'({dealloc_cl, dealloc_idx}), 32'({cl, IW'(idx)}));
    endtask

    // Monitor: compare every produced answer with the queue head
    always @(negedge clk) begin
        if (rst_n && (ref_valid === 1'b1 || cell_drop === 1'b1)) begin
            logic [10:0] act;
            act = cell_drop ? {2'd2, 1'b0, IW'(0)} : {ref_new ? 2'd1 : 2'd0, ref_cl, ref_idx};
            if (exp_q.size() == 0) check(0, "R6 unexpected answer", 32'(act), 32'h0);
            else begin
                logic [10:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(act === e && !(ref_valid && cell_drop), t, 32'(act), 32'(e));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check({ref_valid, cell_drop, host_rd_valid, dealloc_valid} === 4'b0,
              "R1 reset outputs", 32'({ref_valid, cell_drop, host_rd_valid, dealloc_valid}), 32'd0);
        rst_n = 1;
        host_read(0, 0, "R1 slot free after reset");
        host_read(1, 255, "R1 message slot free after reset");

        send_cell(0, 16'h1234, 10'd0, "R3 first circuit new idx0");
        send_cell(0, 16'h1234, 10'd0, "R2 R6 repeat hits idx0");
        send_cell(0, 16'h0042, 10'd0, "R3 second circuit idx1");
        send_cell(1, 16'h1234, 10'd5, "R5 message new idx0");
        send_cell(1, 16'h1234, 10'd6, "R5 other MID new idx1");
        send_cell(1, 16'h1234, 10'd5, "R5 message hit idx0");
        idle(2);

        host_read(1, 1, "R7 message key layout");
        host_read(0, 1, "R7 circuit key layout");

        // R4 R6: fill circuit table back to back, then overflow
        for (int i = 2; i < N; i++) send_cell(0, 16'h2000 + 16'(i), 10'd0, "R6 fill circuit");
        send_cell(0, 16'h3000, 10'd0, "R4 full table drops");
        send_cell(0, 16'h1234, 10'd0, "R4 old entry still hits");
        send_cell(0, 16'h3000, 10'd0, "R4 drop left table unchanged");
        idle(2);

        host_delete(0, 1, "R8 delete used slot");
        host_read(0, 1, "R8 deleted slot free");
        send_cell(0, 16'h3000, 10'd0, "R3 freed slot reused idx1");
        idle(2);
        host_delete(1, 200, "R8 delete free slot silent");

        // R9: host read raised together with a cell must wait
        @(negedge clk);
        expect_cell(1, 16'h0777, 10'd3, "R9 cell beside host request");
        cell_valid = 1; cell_is_cl = 1; cell_vci = 16'h0777; cell_mid = 10'd3;
        host_req = 1; host_op_del = 0; host_sel_cl = 1; host_idx = 8'd2;
        #1 check(host_accept === 1'b0, "R9 no accept during cell", 32'(host_accept), 32'd0);
        @(negedge clk);
        cell_valid = 0;
        check(host_rd_valid === 1'b0, "R9 no read result yet", 32'(host_rd_valid), 32'd0);
        #1 check(host_accept === 1'b1, "R9 accept when idle", 32'(host_accept), 32'd1);
        @(negedge clk);
        host_req = 0;
        check(host_rd_valid === 1'b1 && host_rd_used === 1'b1 && host_rd_key === {16'h0777, 10'd3},
              "R9 R7 deferred read", 32'(host_rd_key), 32'({16'h0777, 10'd3}));
        idle(3);
        check(exp_q.size() == 0, "R6 all answers seen", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule